// File: doc/BRIEF.md
# Expansion Slot Address Router

This block sits between a CPU bus master and the expansion slots of a backplane. It takes one request at a time, made up of an address, a transfer size, a write flag, write data and a mode bit. It works out which slot the request is for and passes it to the right destination. Slot-space requests take the slot number from address bits 27:24, which gives each slot a 16 MB window. Board-space requests take the slot number from bits 31:28, which gives each slot a 256 MB window.

There are three possible destinations. Slot 0 in slot space is always the home port, which holds the CPU board's own interface registers. A slot marked present in the configuration vector goes to the shared card port. That port reports the slot index and the mode, so one board fitted in any slot (slot 2 in the usual build) answers in both address spaces. Every other slot goes to an internal timeout responder, which ends the transfer with a bus error. The same watchdog also ends a transfer with a bus error when a real destination does not answer in time.

Top module: `slot_router`

## Requirements
- R1: After reset, req_ready is 1, and home_valid, card_valid and rsp_valid are all 0.
- R2: The slot index is req_addr[27:24] when req_board is 0 and req_addr[31:28] when req_board is 1. A card-port request shows that index on card_slot and the mode on card_board.
- R3: A slot-space request (req_board = 0) to slot 0 always goes to the home port, whatever slot_present[0] holds. A board-space request to slot 0 follows slot_present[0].
- R4: Apart from the cases in R3 and R5, a request goes to the card port when slot_present[index] is 1. This holds in both modes for the same index.
- R5: A board-space request to index 15 never reaches the card port, even when slot_present[15] is 1. It is treated as an empty slot.
- R6: A request to an empty slot gives rsp_valid with rsp_err = 1 and rsp_rdata = 0. This happens exactly TIMEOUT cycles (default 16) after the edge that accepted the request.
- R7: The address, size code, write flag and write data reach the selected port unchanged. They stay stable while that port's valid is high.
- R8: When the selected port raises ready or err, rsp_valid follows at the next clock edge. It carries that port's err flag. rsp_rdata is the port's read data for an error-free read and 0 otherwise.
- R9: If the selected port gives no ready or err within TIMEOUT cycles, its valid is dropped and the response is a bus error with zero data. If an acknowledge arrives in the last cycle of the window, the acknowledge wins.
- R10: Only one request is in flight at a time. req_ready stays 0 from the accepting edge until the edge that raises rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router idle; a request is accepted at this edge |
| req_board | input | 1 | 1 = board-space decode, 0 = slot-space decode |
| req_addr | input | 32 | Request address |
| req_size | input | 2 | Transfer size code, passed through |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write data |
| slot_present | input | 16 | One bit per slot: a target is fitted |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion is a bus error |
| rsp_rdata | output | 32 | Read data |
| home_valid | output | 1 | Request to the local register port |
| home_addr | output | 32 | Address to the home port |
| home_size | output | 2 | Size code to the home port |
| home_write | output | 1 | Write flag to the home port |
| home_wdata | output | 32 | Write data to the home port |
| home_ready | input | 1 | Home port completes normally |
| home_err | input | 1 | Home port completes with an error |
| home_rdata | input | 32 | Home port read data |
| card_valid | output | 1 | Request to a fitted expansion target |
| card_slot | output | 4 | Decoded slot index |
| card_board | output | 1 | Mode of the forwarded request |
| card_addr | output | 32 | Address to the card port |
| card_size | output | 2 | Size code to the card port |
| card_write | output | 1 | Write flag to the card port |
| card_wdata | output | 32 | Write data to the card port |
| card_ready | input | 1 | Card completes normally |
| card_err | input | 1 | Card completes with an error |
| card_rdata | input | 32 | Card read data |

## Verification
A destination valid rises in the cycle right after the accepting edge. The bench counts cycles from that edge and checks the routing and the forwarded fields in each of those cycles. An acknowledge driven in cycle k produces rsp_valid one edge later, so the bench looks for the response at the first negative edge after that. An empty slot, or a target that never answers, completes TIMEOUT edges after acceptance. The bench checks that rsp_valid stays low in every cycle before that point, including the last-cycle acknowledge boundary. After each completion it also checks that the response pulse lasts one cycle and that the router is idle again.

// File: rtl/slot_rt_pkg.sv
package slot_rt_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int SIZE_W    = 2;
    localparam int SLOT_W    = 4;
    localparam int NSLOT     = 1 << SLOT_W;
    localparam int TOP_W     = 2 * SLOT_W;
    localparam int SLOT_LO   = ADDR_W - TOP_W;
    localparam int LAST_SLOT = NSLOT - 1;

    typedef enum logic [1:0] {
        RT_HOME = 2'd0,
        RT_CARD = 2'd1,
        RT_VOID = 2'd2
    } route_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    // Board space uses the upper nibble of the top byte, slot space the lower.
    function automatic logic [SLOT_W-1:0] pick_slot(
        input logic [TOP_W-1:0] top,
        input logic             board
    );
        return board ? top[TOP_W-1:SLOT_W] : top[SLOT_W-1:0];
    endfunction

    function automatic route_e pick_route(
        input logic [SLOT_W-1:0] slot,
        input logic              board,
        input logic [NSLOT-1:0]  present
    );
        if (!board && slot == '0)
            return RT_HOME;
        if (board && slot == SLOT_W'(LAST_SLOT))
            return RT_VOID;
        return present[slot] ? RT_CARD : RT_VOID;
    endfunction

endpackage

// File: rtl/slot_decode.sv
module slot_decode
    import slot_rt_pkg::*;
(
    input  logic [TOP_W-1:0]  top,
    input  logic              board,
    input  logic [NSLOT-1:0]  present,
    output logic [SLOT_W-1:0] slot,
    output route_e            route
);

    always_comb begin
        slot  = pick_slot(top, board);
        route = pick_route(slot, board, present);
    end

endmodule

// File: rtl/slot_watchdog.sv
module slot_watchdog #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    assign expire = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (run && !expire)
            cnt <= cnt + 1'b1;
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= LAST));

endmodule

// File: rtl/slot_rsp_sel.sv
module slot_rsp_sel
    import slot_rt_pkg::*;
(
    input  route_e            route,
    input  logic              run,
    input  logic              write,
    input  logic              expire,
    input  logic              home_ready,
    input  logic              home_err,
    input  logic [DATA_W-1:0] home_rdata,
    input  logic              card_ready,
    input  logic              card_err,
    input  logic [DATA_W-1:0] card_rdata,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);

    logic              ack;
    logic              ack_err;
    logic [DATA_W-1:0] ack_data;

    always_comb begin
        unique case (route)
            RT_HOME: begin
                ack      = home_ready || home_err;
                ack_err  = home_err;
                ack_data = home_rdata;
            end
            RT_CARD: begin
                ack      = card_ready || card_err;
                ack_err  = card_err;
                ack_data = card_rdata;
            end
            default: begin
                ack      = 1'b0;
                ack_err  = 1'b1;
                ack_data = '0;
            end
        endcase

        done  = run && (ack || expire);
        err   = ack ? ack_err : 1'b1;
        rdata = (ack && !ack_err && !write) ? ack_data : '0;
    end

endmodule

// File: rtl/slot_router.sv
module slot_router
    import slot_rt_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_board,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [NSLOT-1:0]    slot_present,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                home_valid,
    output logic [ADDR_W-1:0]   home_addr,
    output logic [SIZE_W-1:0]   home_size,
    output logic                home_write,
    output logic [DATA_W-1:0]   home_wdata,
    input  logic                home_ready,
    input  logic                home_err,
    input  logic [DATA_W-1:0]   home_rdata,
    output logic                card_valid,
    output logic [SLOT_W-1:0]   card_slot,
    output logic                card_board,
    output logic [ADDR_W-1:0]   card_addr,
    output logic [SIZE_W-1:0]   card_size,
    output logic                card_write,
    output logic [DATA_W-1:0]   card_wdata,
    input  logic                card_ready,
    input  logic                card_err,
    input  logic [DATA_W-1:0]   card_rdata
);

    logic              busy;
    xfer_t             cur;
    route_e            cur_route;
    logic [SLOT_W-1:0] cur_slot;
    logic              cur_board;

    logic [SLOT_W-1:0] dec_slot;
    route_e            dec_route;
    logic              accept;
    logic              expire;
    logic              done;
    logic              fin_err;
    logic [DATA_W-1:0] fin_rdata;

    assign req_ready = !busy;
    assign accept    = req_valid && !busy;

    slot_decode u_decode (
        .top     (req_addr[ADDR_W-1:SLOT_LO]),
        .board   (req_board),
        .present (slot_present),
        .slot    (dec_slot),
        .route   (dec_route)
    );

    slot_watchdog #(.LIMIT(TIMEOUT)) u_watchdog (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .run    (busy),
        .expire (expire)
    );

    slot_rsp_sel u_rsp_sel (
        .route      (cur_route),
        .run        (busy),
        .write      (cur.write),
        .expire     (expire),
        .home_ready (home_ready),
        .home_err   (home_err),
        .home_rdata (home_rdata),
        .card_ready (card_ready),
        .card_err   (card_err),
        .card_rdata (card_rdata),
        .done       (done),
        .err        (fin_err),
        .rdata      (fin_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cur       <= '0;
            cur_route <= RT_VOID;
            cur_slot  <= '0;
            cur_board <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                busy      <= 1'b1;
                cur       <= '{addr: req_addr, size: req_size,
                               write: req_write, wdata: req_wdata};
                cur_route <= dec_route;
                cur_slot  <= dec_slot;
                cur_board <= req_board;
            end else if (done) begin
                busy      <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_err   <= fin_err;
                rsp_rdata <= fin_rdata;
            end
        end
    end

    assign home_valid = busy && (cur_route == RT_HOME);
    assign home_addr  = cur.addr;
    assign home_size  = cur.size;
    assign home_write = cur.write;
    assign home_wdata = cur.wdata;

    assign card_valid = busy && (cur_route == RT_CARD);
    assign card_slot  = cur_slot;
    assign card_board = cur_board;
    assign card_addr  = cur.addr;
    assign card_size  = cur.size;
    assign card_write = cur.write;
    assign card_wdata = cur.wdata;

    // R3
    home_slot_chk: assert property (@(posedge clk) disable iff (rst)
        home_valid |-> (!cur_board && cur.addr[SLOT_LO +: SLOT_W] == '0));

    // R5
    last_board_chk: assert property (@(posedge clk) disable iff (rst)
        card_valid |-> !(card_board && card_slot == SLOT_W'(LAST_SLOT)));

    // R7
    card_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (card_valid && !card_ready && !card_err && !expire)
        |=> (card_valid && $stable(card_addr) && $stable(card_wdata)));

    // R6
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R10
    single_out_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> $past(busy));

endmodule

// File: tb/slot_router_tb_top.sv
`timescale 1ns/1ps
module slot_router_tb_top;

    localparam int T = 16;
    localparam int R_HOME = 0;
    localparam int R_CARD = 1;
    localparam int R_VOID = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_board = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [15:0] slot_present = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        home_valid, home_write;
    logic [31:0] home_addr, home_wdata;
    logic [1:0]  home_size;
    logic        home_ready = 1'b0, home_err = 1'b0;
    logic [31:0] home_rdata = '0;
    logic        card_valid, card_board, card_write;
    logic [3:0]  card_slot;
    logic [31:0] card_addr, card_wdata;
    logic [1:0]  card_size;
    logic        card_ready = 1'b0, card_err = 1'b0;
    logic [31:0] card_rdata = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    slot_router #(.TIMEOUT(T)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_board(req_board),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .slot_present(slot_present),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .home_valid(home_valid), .home_addr(home_addr), .home_size(home_size),
        .home_write(home_write), .home_wdata(home_wdata),
        .home_ready(home_ready), .home_err(home_err), .home_rdata(home_rdata),
        .card_valid(card_valid), .card_slot(card_slot), .card_board(card_board),
        .card_addr(card_addr), .card_size(card_size), .card_write(card_write),
        .card_wdata(card_wdata), .card_ready(card_ready), .card_err(card_err),
        .card_rdata(card_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_slot(input logic [31:0] a, input logic b);
        return b ? int'(a[31:28]) : int'(a[27:24]);
    endfunction

    function automatic int exp_route(input logic [31:0] a, input logic b,
                                     input logic [15:0] pop);
        int s = exp_slot(a, b);
        if (!b && s == 0) return R_HOME;
        if (b && s == 15) return R_VOID;
        return pop[s] ? R_CARD : R_VOID;
    endfunction

    // delay: cycle index after acceptance where the target answers (>= T: never)
    task automatic txn(input logic [31:0] a, input logic b, input logic [1:0] sz,
                       input logic wr, input logic [31:0] wd, input logic [15:0] pop,
                       input int delay, input logic aerr, input logic [31:0] ad);
        int route = exp_route(a, b, pop);
        int kend  = (route != R_VOID && delay < T) ? delay : T - 1;
        bit acked = (route != R_VOID && delay < T);
        logic [31:0] exp_data = (acked && !aerr && !wr) ? ad : 32'h0;
        chk(req_ready === 1'b1, "R10", "idle before request", 64'(req_ready), 64'd1);
        req_addr = a; req_board = b; req_size = sz; req_write = wr;
        req_wdata = wd; slot_present = pop; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k <= kend; k++) begin
            chk(home_valid === (route == R_HOME), "R3", "home_valid",
                64'(home_valid), 64'(route == R_HOME));
            chk(card_valid === (route == R_CARD), (b && exp_slot(a, b) == 15) ? "R5" : "R4",
                "card_valid", 64'(card_valid), 64'(route == R_CARD));
            chk(req_ready === 1'b0 && rsp_valid === 1'b0, "R10", "busy window",
                64'({req_ready, rsp_valid}), 64'd0);
            if (route == R_CARD) begin
                chk(card_slot === 4'(exp_slot(a, b)) && card_board === b, "R2",
                    "card slot/mode", 64'({card_slot, card_board}),
                    64'({4'(exp_slot(a, b)), b}));
                chk({card_addr, card_size, card_write, card_wdata} === {a, sz, wr, wd},
                    "R7", "card fields", 64'(card_addr), 64'(a));
            end
            if (route == R_HOME)
                chk({home_addr, home_size, home_write, home_wdata} === {a, sz, wr, wd},
                    "R7", "home fields", 64'(home_wdata), 64'(wd));
            if (acked && k == kend) begin
                if (route == R_HOME) begin
                    home_ready = !aerr; home_err = aerr; home_rdata = ad;
                end else begin
                    card_ready = !aerr; card_err = aerr; card_rdata = ad;
                end
            end
            @(posedge clk);
            @(negedge clk);
            home_ready = 1'b0; home_err = 1'b0; card_ready = 1'b0; card_err = 1'b0;
        end
        chk(rsp_valid === 1'b1, acked ? "R8" : (route == R_VOID ? "R6" : "R9"),
            "rsp_valid at due cycle", 64'(rsp_valid), 64'd1);
        chk(rsp_err === (acked ? aerr : 1'b1), acked ? "R8" : "R6", "rsp_err",
            64'(rsp_err), 64'(acked ? aerr : 1'b1));
        chk(rsp_rdata === exp_data, acked ? "R8" : "R9", "rsp_rdata",
            64'(rsp_rdata), 64'(exp_data));
        chk(home_valid === 1'b0 && card_valid === 1'b0, "R9", "valids dropped",
            64'({home_valid, card_valid}), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R10", "one-cycle pulse",
            64'({rsp_valid, req_ready}), 64'b01);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1 && home_valid === 1'b0 && card_valid === 1'b0 &&
            rsp_valid === 1'b0, "R1", "reset state",
            64'({req_ready, home_valid, card_valid, rsp_valid}), 64'b1000);

        // R3: slot space slot 0 goes home even with present[0] clear
        txn(32'hF0FF_FFE8, 1'b0, 2'd0, 1'b0, 32'h0, 16'h0000, 2, 1'b0, 32'h0000_0080);
        // R3: board space slot 0 follows present[0]
        txn(32'h0123_4560, 1'b1, 2'd2, 1'b0, 32'h0, 16'h0001, 1, 1'b0, 32'hCAFE_0001);
        txn(32'h0123_4560, 1'b1, 2'd2, 1'b0, 32'h0, 16'h0000, 0, 1'b0, 32'h0);
        // R4/R2: board in slot 2, both spaces
        txn(32'hF200_0010, 1'b0, 2'd1, 1'b1, 32'h1234_5678, 16'h0004, 0, 1'b0, 32'hDEAD_BEEF);
        txn(32'h2000_0040, 1'b1, 2'd2, 1'b0, 32'h0, 16'h0004, 3, 1'b0, 32'hA5A5_5A5A);
        // R5: board index 15 empty even when present
        txn(32'hF000_0000, 1'b1, 2'd2, 1'b0, 32'h0, 16'hFFFF, 0, 1'b0, 32'h1111_1111);
        // slot space index 15 reaches the card port
        txn(32'h0F00_0000, 1'b0, 2'd2, 1'b0, 32'h0, 16'h8000, 0, 1'b0, 32'h2222_2222);
        // R6: empty slot timeout
        txn(32'h0500_0000, 1'b0, 2'd0, 1'b1, 32'hFF, 16'h0004, 0, 1'b0, 32'h0);
        // R9: silent target, and an answer in the last window cycle
        txn(32'h2000_0000, 1'b1, 2'd2, 1'b0, 32'h0, 16'h0004, T, 1'b0, 32'h3333_3333);
        txn(32'h2000_0000, 1'b1, 2'd2, 1'b0, 32'h0, 16'h0004, T - 1, 1'b0, 32'h4444_4444);
        // R8: target error
        txn(32'h0200_0008, 1'b0, 2'd2, 1'b0, 32'h0, 16'h0004, 1, 1'b1, 32'h5555_5555);

        for (int i = 0; i < 300; i++) begin
            logic [31:0] a = $urandom;
            logic        b = 1'($urandom);
            logic [15:0] p = 16'($urandom);
            txn(a, b, 2'($urandom_range(0, 2)), 1'($urandom), $urandom, p,
                int'($urandom_range(0, T + 2)), ($urandom_range(0, 7) == 0), $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule